// File: doc/BRIEF.md
# Oscillator Auto-Trim Controller

This block tunes the trim code of an on-chip high-speed oscillator so that it runs at 22.1184 MHz. It measures against a 32.768 kHz reference clock. The controller runs on the oscillator's own clock and samples the reference through a synchronizer. It counts fast cycles over a window of several reference periods and compares the total with the ideal count. After each window that misses, it moves the trim code one step toward the ideal count.

A 2-bit loop field sets two things at once: the window length and how many missed windows are allowed before the attempt is abandoned. The block reports lock while the measured total stays within a small tolerance. It aborts on a trim failure, and it also aborts when the reference clock looks wrong. Both aborts clear the enable bit. Each abort raises its own sticky flag, and each flag drives the shared interrupt only when its own enable bit is set.

Software uses a 3-bit register bus with three registers:

| Address | Contents |
|---|---|
| 0, control | bit 0 enable, bits 2:1 loop select |
| 1, interrupt enables | bit 0 failure, bit 1 clock error |
| 2, status | bit 0 lock (read-only), bit 1 failure flag, bit 2 clock-error flag |

Address 3 reads as zero.

Top module: `osc_trim_ctrl`

## Requirements
- R1: A write of 1 to control bit 0 while it is 0 starts a new trim run. Measurement begins at the first reference rising edge after that write. The trim code never changes while the enable bit is 0.
- R2: Loop select (control bits 2:1) value s sets a window of 4·2^s reference periods and a retry limit of RETRY_BASE·2^s missed windows. With the default RETRY_BASE this gives 64, 128, 256 or 512.
- R3: At the end of each window, the fast-cycle total is compared with EXP_PER_REF times the window length. If the total is more than LOCK_TOL below, the trim code rises by 1. If it is more than LOCK_TOL above, the trim code falls by 1. Otherwise the code holds. The code saturates at 0 and at its maximum.
- R4: A window within tolerance sets lock and resets the missed-window counter to 0.
- R5: When the missed-window count reaches the retry limit without lock, the failure flag (status bit 1) is set and the enable bit is cleared, and that last window makes no trim step.
- R6: The clock-error flag (status bit 2) is set and the enable bit is cleared in either of two cases: a single reference period measures fewer than EXP_PER_REF/2 fast cycles, or more than EXP_PER_REF + EXP_PER_REF/2 fast cycles.
- R7: The interrupt is high exactly when the failure flag is set with interrupt-enable bit 0, or the clock-error flag is set with interrupt-enable bit 1. Writing 1 to a flag's status bit clears it.
- R8: The lock bit is read-only, never drives the interrupt, and reads 0 once the enable bit is 0.
- R9: After reset, all registers read 0, the trim code equals TRIM_INIT and the interrupt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock from the oscillator being trimmed |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Low-speed reference clock, asynchronous to clk |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address for reads and writes |
| bus_wdata | input | 3 | Register write data |
| bus_rdata | output | 3 | Register read data for bus_addr |
| trim_code | output | TRIM_W | Trim code driven to the oscillator |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a missed-window counter that must be reset by an intermediate lock. Without that reset, a later drift would push the count past the retry limit and end in a false failure. The bench drives the reference so that each period lasts a number of fast cycles set by the live trim code. In that test the bench first lets the controller lock two steps from the start. It then moves the modelled ideal code while the controller is locked, so that the missed windows before and after the lock together reach the limit. The bench also counts reference edges between trim steps to confirm the window length. It injects a single stretched period and, separately, a single shortened period to reach the clock-error path.

// File: rtl/osc_trim_ctrl.sv
module osc_trim_ctrl #(
  parameter int EXP_PER_REF = 675,
  parameter int RETRY_BASE  = 64,
  parameter int TRIM_W      = 8,
  parameter int TRIM_INIT   = 128,
  parameter int LOCK_TOL    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_clk,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [2:0]        bus_wdata,
  output logic [2:0]        bus_rdata,
  output logic [TRIM_W-1:0] trim_code,
  output logic              irq
);

  localparam int PER_LO = EXP_PER_REF / 2;
  localparam int PER_HI = EXP_PER_REF + EXP_PER_REF / 2;
  localparam int PER_W  = $clog2(PER_HI + 2);
  localparam int SUM_W  = $clog2(32 * (PER_HI + 2));
  localparam int RET_W  = $clog2(RETRY_BASE * 8 + 1);

  logic [2:0]        ref_s;
  logic              en, meas_on, locked;
  logic [1:0]        sel;
  logic              ie_fail, ie_err, f_fail, f_err;
  logic [PER_W-1:0]  per_cnt;
  logic [SUM_W-1:0]  sum;
  logic [5:0]        win_cnt;
  logic [RET_W-1:0]  retry_cnt;
  logic [TRIM_W-1:0] trim;

  wire ref_edge = ref_s[1] & ~ref_s[2];
  wire wr_ctrl  = bus_wr && bus_addr == 2'd0;
  wire wr_ie    = bus_wr && bus_addr == 2'd1;
  wire wr_stat  = bus_wr && bus_addr == 2'd2;
  wire start    = wr_ctrl && bus_wdata[0] && !en;

  wire [5:0]       win_len   = 6'd4 << sel;
  wire [RET_W-1:0] retry_lim = RET_W'(RETRY_BASE) << sel;
  wire [SUM_W-1:0] target    = SUM_W'(EXP_PER_REF * 4) << sel;
  wire [SUM_W-1:0] sum_next  = sum + SUM_W'(per_cnt);
  wire [SUM_W-1:0] lo_bound  = target - SUM_W'(LOCK_TOL);
  wire [SUM_W-1:0] hi_bound  = target + SUM_W'(LOCK_TOL);
  wire             too_slow  = sum_next < lo_bound;
  wire             in_tol    = !too_slow && sum_next <= hi_bound;
  wire             win_end   = win_cnt >= win_len - 6'd1;

  wire clk_err  = en && meas_on &&
                  ((ref_edge && per_cnt < PER_W'(PER_LO)) || per_cnt > PER_W'(PER_HI));
  wire win_done = en && meas_on && ref_edge && win_end && !clk_err;
  wire give_up  = win_done && !in_tol && retry_cnt >= retry_lim - RET_W'(1);
  wire step     = win_done && !in_tol && !give_up;

  assign trim_code = trim;
  assign irq       = (f_fail && ie_fail) || (f_err && ie_err);

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {sel, en};
      2'd1:    bus_rdata = {1'b0, ie_err, ie_fail};
      2'd2:    bus_rdata = {f_err, f_fail, locked};
      default: bus_rdata = 3'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_s   <= '0;
      per_cnt <= '0;
    end else begin
      ref_s <= {ref_s[1:0], ref_clk};
      if (ref_edge)
        per_cnt <= PER_W'(1);
      else if (per_cnt <= PER_W'(PER_HI))
        per_cnt <= per_cnt + PER_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en      <= 1'b0;
      sel     <= 2'd0;
      ie_fail <= 1'b0;
      ie_err  <= 1'b0;
      f_fail  <= 1'b0;
      f_err   <= 1'b0;
    end else begin
      if (clk_err || give_up) en <= 1'b0;
      else if (wr_ctrl)       en <= bus_wdata[0];
      if (wr_ctrl) sel <= bus_wdata[2:1];
      if (wr_ie) begin
        ie_fail <= bus_wdata[0];
        ie_err  <= bus_wdata[1];
      end
      f_fail <= give_up || (f_fail && !(wr_stat && bus_wdata[1]));
      f_err  <= clk_err || (f_err && !(wr_stat && bus_wdata[2]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meas_on   <= 1'b0;
      win_cnt   <= '0;
      sum       <= '0;
      retry_cnt <= '0;
      locked    <= 1'b0;
      trim      <= TRIM_W'(TRIM_INIT);
    end else begin
      if (!en || start || clk_err || give_up) meas_on <= 1'b0;
      else if (ref_edge)                      meas_on <= 1'b1;

      if (!meas_on || (ref_edge && win_end)) begin
        win_cnt <= '0;
        sum     <= '0;
      end else if (ref_edge) begin
        win_cnt <= win_cnt + 6'd1;
        sum     <= sum_next;
      end

      if (start)
        retry_cnt <= '0;
      else if (win_done)
        retry_cnt <= (in_tol || give_up) ? '0 : retry_cnt + RET_W'(1);

      if (!en || start) locked <= 1'b0;
      else if (win_done) locked <= in_tol;

      if (step) begin
        if (too_slow && trim != '1)       trim <= trim + TRIM_W'(1);
        else if (!too_slow && trim != '0) trim <= trim - TRIM_W'(1);
      end
    end
  end

  AST_FAIL_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_fail) |-> !en); // R5
  AST_ERR_CLEARS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_err) |-> !en); // R6
  AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    trim != $past(trim) |-> (trim - $past(trim) == TRIM_W'(1) ||
                             $past(trim) - trim == TRIM_W'(1))); // R3
  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> $stable(trim)); // R1
  AST_LOCK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> $past(en)); // R8

endmodule

// File: tb/osc_trim_ctrl_test.sv
module osc_trim_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int EXP   = 40;
  localparam int RB    = 4;
  localparam int TW    = 8;
  localparam int TINIT = 128;

  logic          clk = 0, rst_n = 0, ref_clk = 0, bus_wr = 0;
  logic [1:0]    bus_addr = 0;
  logic [2:0]    bus_wdata = 0;
  logic [2:0]    bus_rdata;
  logic [TW-1:0] trim_code;
  logic          irq;

  int checks = 0, errors = 0;
  int good = TINIT;
  int ph = 0, plen = EXP, ref_edges = 0, inj_len = 0;

  osc_trim_ctrl #(.EXP_PER_REF(EXP), .RETRY_BASE(RB), .TRIM_W(TW),
                  .TRIM_INIT(TINIT), .LOCK_TOL(1)) uut (
    .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trim_code(trim_code), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model: period in fast cycles follows the live trim code.
  always @(posedge clk) begin
    if (ph >= plen - 1) begin
      ph        <= 0;
      ref_clk   <= 1'b1;
      ref_edges <= ref_edges + 1;
      if (inj_len != 0) begin
        plen    <= inj_len;
        inj_len <= 0;
      end else
        plen <= EXP + int'(trim_code) - good;
    end else begin
      ph <= ph + 1;
      if (ph + 1 == plen / 2) ref_clk <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [2:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 0; good = TINIT;
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wait_trim_change(output int e);
    logic [TW-1:0] t0 = trim_code;
    e = -1;
    for (int i = 0; i < 8000; i++) begin
      @(negedge clk);
      if (trim_code != t0) begin e = ref_edges; return; end
    end
  endtask

  task automatic wait_en_low(output bit ok);
    logic [2:0] d;
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd0, d);
      if (!d[0]) begin ok = 1; return; end
    end
  endtask

  task automatic wait_lock(output bit ok);
    logic [2:0] d;
    ok = 0;
    for (int i = 0; i < 30000; i++) begin
      rd(2'd2, d);
      if (d[0]) begin ok = 1; return; end
    end
  endtask

  task automatic test_reset();
    logic [2:0] d;
    do_reset();
    rd(2'd0, d); chk(d == 0, "R9 control reset", d, 0);
    rd(2'd1, d); chk(d == 0, "R9 irq-enable reset", d, 0);
    rd(2'd2, d); chk(d == 0, "R9 status reset", d, 0);
    chk(trim_code == TW'(TINIT), "R9 trim reset", trim_code, TINIT);
    chk(irq == 0, "R9 irq reset", irq, 0);
    repeat (3 * EXP) @(negedge clk);
    chk(trim_code == TW'(TINIT), "R1 idle trim frozen", trim_code, TINIT);
  endtask

  task automatic test_fail(input logic [1:0] s, input int win, input int lim);
    int e1, e2; bit ok; logic [2:0] d; logic [TW-1:0] t;
    do_reset();
    good = TINIT + 10;
    wr(2'd0, {s, 1'b1});
    wait_trim_change(e1);
    wait_trim_change(e2);
    chk(e1 >= 0 && e2 - e1 == win, "R2 window length", e2 - e1, win);
    wait_en_low(ok);
    chk(ok, "R5 enable cleared on retry limit", ok, 1);
    chk(trim_code == TW'(TINIT + lim - 1), "R5 R2 steps before failure",
        trim_code, TINIT + lim - 1);
    rd(2'd2, d); chk(d == 3'b010, "R5 failure flag only", d, 3'b010);
    chk(irq == 0, "R7 masked failure", irq, 0);
    wr(2'd1, 3'b001);
    chk(irq == 1, "R7 failure irq enabled", irq, 1);
    wr(2'd2, 3'b001);
    rd(2'd2, d); chk(d == 3'b010, "R8 lock bit write ignored", d, 3'b010);
    wr(2'd2, 3'b010);
    rd(2'd2, d); chk(d == 0, "R7 failure flag cleared", d, 0);
    chk(irq == 0, "R7 irq drops after clear", irq, 0);
    t = trim_code;
    repeat (3 * win * EXP) @(negedge clk);
    chk(trim_code == t, "R1 trim frozen when disabled", trim_code, t);
  endtask

  task automatic test_lock();
    bit ok; logic [2:0] d;
    do_reset();
    good = TINIT + 5;
    wr(2'd1, 3'b011);
    wr(2'd0, 3'b101);
    wait_lock(ok);
    chk(ok, "R3 lock reached", ok, 1);
    chk(trim_code == TW'(good), "R3 trim converged", trim_code, good);
    chk(irq == 0, "R8 lock raises no irq", irq, 0);
    repeat (40 * EXP) @(negedge clk);
    rd(2'd2, d); chk(d == 3'b001, "R4 stays locked, no flags", d, 3'b001);
    chk(trim_code == TW'(good), "R3 trim held while locked", trim_code, good);
    wr(2'd2, 3'b001);
    rd(2'd2, d); chk(d[0] == 1, "R8 lock not cleared by write", d[0], 1);
    wr(2'd0, 3'b100);
    @(negedge clk);
    rd(2'd2, d); chk(d[0] == 0, "R8 lock clears when disabled", d[0], 0);
  endtask

  task automatic test_retry_reset();
    bit ok; logic [2:0] d;
    do_reset();
    good = TINIT + 2;
    wr(2'd0, 3'b001);
    wait_lock(ok);
    chk(ok, "R4 first lock", ok, 1);
    good = TINIT + 4;
    repeat (2 * 4 * EXP) @(negedge clk);
    wait_lock(ok);
    chk(ok, "R4 relock after drift", ok, 1);
    rd(2'd2, d); chk(d == 3'b001, "R4 no failure after relock", d, 3'b001);
    rd(2'd0, d); chk(d[0] == 1, "R4 still enabled", d[0], 1);
    chk(trim_code == TW'(good), "R4 trim at new target", trim_code, good);
  endtask

  task automatic test_clk_err();
    bit ok; logic [2:0] d;
    do_reset();
    wr(2'd0, 3'b001);
    repeat (6 * EXP) @(negedge clk);
    inj_len = 3 * EXP;
    wait_en_low(ok);
    chk(ok, "R6 long period clears enable", ok, 1);
    rd(2'd2, d); chk(d == 3'b100, "R6 clock-error flag only", d, 3'b100);
    chk(irq == 0, "R7 masked clock error", irq, 0);
    wr(2'd1, 3'b001);
    chk(irq == 0, "R7 other enable does not unmask", irq, 0);
    wr(2'd1, 3'b010);
    chk(irq == 1, "R7 clock-error irq enabled", irq, 1);
    wr(2'd2, 3'b100);
    rd(2'd2, d); chk(d == 0, "R7 clock-error flag cleared", d, 0);
    chk(irq == 0, "R7 irq drops", irq, 0);
    wr(2'd0, 3'b001);
    repeat (6 * EXP) @(negedge clk);
    rd(2'd2, d); chk(d[2] == 0, "R6 nominal periods raise no error", d[2], 0);
    inj_len = EXP / 4;
    wait_en_low(ok);
    chk(ok, "R6 short period clears enable", ok, 1);
    rd(2'd2, d); chk(d[2] == 1, "R6 short period flagged", d[2], 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_fail(2'd0, 4, RB);
    test_fail(2'd1, 8, 2 * RB);
    test_lock();
    test_retry_reset();
    test_clk_err();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule